// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Word Deserializer

This block sits behind a clock-and-data recovery stage. Each clock brings one retimed serial bit, and the block rebuilds fixed-width words from that stream. The bit comes from one of two sources: the external line or an internal loopback path from the local serializer. A select input picks the source, so a link can be tested without the transmission medium.

Word boundaries come from a comma pattern. The pattern is two zeros followed by five ones, counted in arrival order. While alignment is enabled and the pattern turns up at any bit offset, the block restarts its word counter there. It then presents that comma word at once with a one-cycle sync pulse. When alignment is disabled, the pattern is ignored and the boundary stays where it was. When the signal-detect flag drops, the presented word reads as all ones, so a lost line never shows random data.

Top module: `desr_top`

## Requirements
- R1: With `loop_en` low the block takes its bits from `line_bit`; with `loop_en` high it takes them from `loop_bit`.
- R2: Within an output word, the first bit received is in `word_out[0]` and the tenth bit received is in `word_out[9]`.
- R3: With no comma realignment, `word_vld` is high for one cycle at every tenth bit. The first strobe comes on the clock that takes in the tenth bit after the reset is released.
- R4: The comma is recognized when the ten most recent bits satisfy word bits [6:0] = 7'b1111100 (bit 0 first received). With `sync_en` high, the word is emitted at the clock that takes in its tenth bit, with `word_vld` high.
- R5: After a realignment, the next words are emitted every ten bits counted from the start of the comma word.
- R6: With `sync_en` low, a comma pattern neither moves the word boundary nor raises `sync_pulse`.
- R7: While `sig_det` is low, `word_out` reads 10'h3FF. While it is high, `word_out` shows the last captured word.
- R8: During reset, `word_vld` and `sync_pulse` are low, and `word_out` is zero while `sig_det` is high.
- R9: `sync_pulse` is high only in a cycle in which `word_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit | input | 1 | Retimed serial bit from the line |
| loop_bit | input | 1 | Serial bit from the internal loopback path |
| loop_en | input | 1 | High selects the loopback bit |
| sync_en | input | 1 | High enables comma alignment |
| sig_det | input | 1 | Low means loss of signal |
| word_out | output | 10 | Reassembled word, bit 0 first received |
| word_vld | output | 1 | One-cycle strobe for a new word |
| sync_pulse | output | 1 | Marks a comma word |

## Verification
The bench uses the default parameters: a ten-bit word and a seven-bit comma pattern. With these values, a comma can be placed at a chosen offset of a few bits, and the emitted words can be predicted by hand. The bench first sends a comma three bits off the reset boundary with alignment on, and checks that the boundary moves. It then sends a comma four bits off with alignment off, and checks that the straddling words are cut at the old boundary.

// File: rtl/desr_pkg.sv
package desr_pkg;
  localparam int unsigned DEF_WORD_W  = 10;
  localparam int unsigned DEF_COMMA_W = 7;
  // arrival order 0,0,1,1,1,1,1 -> bit0 is first received
  localparam logic [DEF_COMMA_W-1:0] DEF_COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/desr_in_sel.sv
module desr_in_sel (
  input  logic line_bit,
  input  logic loop_bit,
  input  logic loop_en,
  output logic sel_bit
);
  always_comb begin
    sel_bit = loop_en ? loop_bit : line_bit;
  end
endmodule

// File: rtl/desr_shift.sv
module desr_shift #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic [WORD_W-1:0] sr_nx
);
  logic [WORD_W-1:0] sr_q;

  // newest bit enters at the top, oldest drifts to bit 0
  always_comb begin
    sr_nx = {bit_in, sr_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nx;
  end
endmodule

// File: rtl/desr_comma.sv
module desr_comma #(
  parameter int unsigned          WORD_W    = 10,
  parameter int unsigned          COMMA_W   = 7,
  parameter logic [COMMA_W-1:0]   COMMA_PAT = 7'b1111100
) (
  input  logic [WORD_W-1:0] window,
  output logic              hit
);
  always_comb begin
    hit = (window[COMMA_W-1:0] == COMMA_PAT);
  end
endmodule

// File: rtl/desr_framer.sv
module desr_framer #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] window,
  input  logic              hit,
  input  logic              sync_en,
  output logic [WORD_W-1:0] word_q,
  output logic              vld_q,
  output logic              sp_q
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [WORD_W-1:0] word_nx;
  logic              realign, emit, vld_nx, sp_nx;

  always_comb begin
    realign = sync_en & hit;
    emit    = realign | (cnt_q == LAST);
    if (emit) cnt_nx = '0;
    else      cnt_nx = cnt_q + 1'b1;
    word_nx = emit ? window : word_q;   // clock enable on the word register
    vld_nx  = emit;
    sp_nx   = realign;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      sp_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      word_q <= word_nx;
      vld_q  <= vld_nx;
      sp_q   <= sp_nx;
    end
  end
endmodule

// File: rtl/desr_top.sv
module desr_top #(
  parameter int unsigned                 WORD_W    = desr_pkg::DEF_WORD_W,
  parameter int unsigned                 COMMA_W   = desr_pkg::DEF_COMMA_W,
  parameter logic [COMMA_W-1:0]          COMMA_PAT = desr_pkg::DEF_COMMA_PAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_bit,
  input  logic              loop_bit,
  input  logic              loop_en,
  input  logic              sync_en,
  input  logic              sig_det,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld,
  output logic              sync_pulse
);
  logic              rst_m, rst_q;
  logic              sel_bit, hit;
  logic [WORD_W-1:0] window, word_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  desr_in_sel i_sel (
    .line_bit (line_bit),
    .loop_bit (loop_bit),
    .loop_en  (loop_en),
    .sel_bit  (sel_bit)
  );

  desr_shift #(.WORD_W(WORD_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_q),
    .bit_in (sel_bit),
    .sr_nx  (window)
  );

  desr_comma #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) i_comma (
    .window (window),
    .hit    (hit)
  );

  desr_framer #(.WORD_W(WORD_W)) i_framer (
    .clk     (clk),
    .rst_n   (rst_q),
    .window  (window),
    .hit     (hit),
    .sync_en (sync_en),
    .word_q  (word_q),
    .vld_q   (word_vld),
    .sp_q    (sync_pulse)
  );

  always_comb begin
    word_out = sig_det ? word_q : '1;
  end
endmodule

// File: rtl/desr_chk.sv
module desr_chk #(
  parameter int unsigned        WORD_W    = 10,
  parameter int unsigned        COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_en,
  input logic              sig_det,
  input logic [WORD_W-1:0] word_out,
  input logic              word_vld,
  input logic              sync_pulse
);
  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap_q <= '0;
    else if (word_vld)     gap_q <= 8'd1;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
  end

  AST_SYNC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> word_vld); // R9

  AST_NO_SYNC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !sync_pulse); // R6

  AST_SYNC_WORD_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && sig_det) |-> (word_out[COMMA_W-1:0] == COMMA_PAT)); // R4

  AST_REGULAR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !sync_pulse) |-> (gap_q == 8'(WORD_W))); // R3

  AST_SYNC_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> (gap_q <= 8'(WORD_W))); // R5
endmodule

bind desr_top desr_chk #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) i_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .sync_en    (sync_en),
  .sig_det    (sig_det),
  .word_out   (word_out),
  .word_vld   (word_vld),
  .sync_pulse (sync_pulse)
);

// File: tb/test_desr_top.sv
module test_desr_top;
  logic       clk, rst_n, line_bit, loop_bit, loop_en, sync_en, sig_det;
  logic [9:0] word_out;
  logic       word_vld, sync_pulse;
  int         checks = 0, errors = 0;
  int         vld_seen = 0, sync_seen = 0;
  logic       last_vld, last_sync;
  logic [9:0] last_word;

  desr_top i_desr_top (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .loop_bit(loop_bit),
    .loop_en(loop_en), .sync_en(sync_en), .sig_det(sig_det),
    .word_out(word_out), .word_vld(word_vld), .sync_pulse(sync_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {loop_en, line word, loopback word}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 10'h2A5, 10'h0F0},
    {1'b1, 10'h155, 10'h3A1},
    {1'b0, 10'h1E3, 10'h3FF},
    {1'b1, 10'h000, 10'h2B4},
    {1'b0, 10'h2CA, 10'h155},
    {1'b1, 10'h3FF, 10'h0C6}
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic lb, input logic pb);
    @(negedge clk);
    line_bit = lb;
    loop_bit = pb;
    @(posedge clk);
    #2;
    last_vld  = word_vld;
    last_sync = sync_pulse;
    last_word = word_out;
    if (word_vld)   vld_seen++;
    if (sync_pulse) sync_seen++;
  endtask

  task automatic send(input logic [9:0] ln, input logic [9:0] lp);
    for (int i = 0; i < 10; i++) step(ln[i], lp[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_bit = 1'b0; loop_bit = 1'b0;
    loop_en = 1'b0; sync_en = 1'b0; sig_det = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R8 vld", {9'b0, word_vld}, 10'h0);
    check("R8 sync", {9'b0, sync_pulse}, 10'h0);
    check("R8 word", word_out, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // table: words at the reset boundary, both sources (R1, R2, R3)
    foreach (VEC[k]) begin
      logic [9:0] exp_w;
      loop_en = VEC[k][20];
      exp_w = VEC[k][20] ? VEC[k][9:0] : VEC[k][19:10];
      vld_seen = 0;
      send(VEC[k][19:10], VEC[k][9:0]);
      check("R3 strobe at tenth bit", {9'b0, last_vld}, 10'h1);
      check("R3 single strobe", 10'(vld_seen), 10'h1);
      check(VEC[k][20] ? "R1 loopback R2" : "R1 line R2", last_word, exp_w);
    end
    loop_en = 1'b0;

    // loss of signal (R7)
    sig_det = 1'b0;
    #1;
    check("R7 forced ones", word_out, 10'h3FF);
    sig_det = 1'b1;
    #1;
    check("R7 restored", word_out, 10'h0C6);

    // realignment three bits off the boundary (R4, R9, R5)
    sync_en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    send(10'h17C, 10'h000);
    check("R4 comma vld", {9'b0, last_vld}, 10'h1);
    check("R9 sync with vld", {9'b0, last_sync}, 10'h1);
    check("R4 comma word", last_word, 10'h17C);
    vld_seen = 0; sync_seen = 0;
    send(10'h2A5, 10'h000);
    check("R5 next word vld", {9'b0, last_vld}, 10'h1);
    check("R5 single strobe", 10'(vld_seen), 10'h1);
    check("R5 next word", last_word, 10'h2A5);
    check("R5 no sync", 10'(sync_seen), 10'h0);

    // comma with alignment off (R6)
    sync_en = 1'b0;
    sync_seen = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(10'h17C >> i, 1'b0);
    check("R6 old boundary vld", {9'b0, last_vld}, 10'h1);
    check("R6 straddle word 1", last_word, 10'h3CF);
    for (int i = 6; i < 10; i++) step(10'h17C >> i, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    check("R6 straddle word 2", last_word, 10'h3F5);
    check("R6 no sync pulse", 10'(sync_seen), 10'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule